// File: doc/BRIEF.md
# Motion-Selective Recursive Temporal Filter

This block smooths an 8-bit pixel stream along the time axis. Each valid input cycle carries two samples for one picture position: the pixel of the field now arriving and the pixel at the same position in the field before it. The block takes the magnitude of their difference as a per-pixel motion test. When that difference is small, the pixel is treated as static and the output is a fixed blend: 0.6 of the current sample plus 0.4 of the previous one, rounded to the nearest integer. When the difference is large, the current sample goes out untouched, so moving edges are not smeared.

The threshold is written through a plain input port. It is taken into use only on a valid pixel flagged as the first of a field, so the decision rule never changes partway through a field. Results leave the block after a two-stage pipeline. The output valid flag marks each result.

Top module: `motion_temporal_filter`

## Requirements
- R1: While rst_ni is low and after reset, valid_o is 0 and px_o is 0 until the first result. The active threshold resets to 0, so every pixel counts as motion until a threshold is loaded.
- R2: valid_o equals valid_i two clock cycles earlier. Each result appears on the second rising edge after its input pair was sampled.
- R3: If |cur_px_i − prev_px_i| is strictly less than the active threshold, px_o is (154·cur_px_i + 102·prev_px_i + 128) >> 8.
- R4: If |cur_px_i − prev_px_i| is greater than or equal to the active threshold, px_o equals cur_px_i. This includes the case where the difference equals the threshold.
- R5: thresh_i is captured only on a cycle where both valid_i and field_start_i are 1. The captured value already applies to that pixel. A change of thresh_i at any other time has no effect on the decisions.
- R6: The blended result is clamped to 255. A static pair of 255 and 255 gives 255, and a static pair of 0 and 0 gives 0.
- R7: px_o holds its last value in every cycle where valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel pair is valid |
| field_start_i | input | 1 | Pixel is the first of a field; loads thresh_i |
| cur_px_i | input | 8 | Pixel of the current field |
| prev_px_i | input | 8 | Co-located pixel of the previous field |
| thresh_i | input | 8 | Motion threshold value |
| valid_o | output | 1 | Output pixel is valid |
| px_o | output | 8 | Filtered pixel |

## Verification
The bench probes the threshold edge from both sides: a difference equal to the threshold and a difference one below it. A design using less-or-equal would blend the first pair when it should pass it through. It changes thresh_i without a field start and checks that the decisions stay the same. A design that loads the threshold continuously would start blending there. It drives 255/255 and 0/0 static pairs, where a design with broken rounding or clamping would wrap or drift by one. A long stream with gaps in valid checks the two-cycle latency and that px_o holds while idle.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic vld;
    logic mot;
    pix_t cur;
    pix_t prev;
  } stage_t;
endpackage

// File: rtl/mtf_thresh_reg.sv
module mtf_thresh_reg
  import mtf_pkg::*;
#(
  parameter pix_t THR_RST = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic field_start_i,
  input  pix_t thresh_i,
  output pix_t thr_act_o,
  output pix_t thr_q_o
);
  logic load;
  assign load = valid_i & field_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_q_o <= THR_RST;
    else if (load) thr_q_o <= thresh_i;
  end

  // a new field uses its own threshold from its first pixel
  assign thr_act_o = load ? thresh_i : thr_q_o;
endmodule

// File: rtl/mtf_motion_det.sv
module mtf_motion_det
  import mtf_pkg::*;
(
  input  pix_t cur_i,
  input  pix_t prev_i,
  input  pix_t thr_i,
  output logic motion_o
);
  pix_t diff;
  always_comb begin
    if (cur_i >= prev_i) diff = cur_i - prev_i;
    else                 diff = prev_i - cur_i;
    motion_o = !(diff < thr_i);
  end
endmodule

// File: rtl/mtf_blend.sv
module mtf_blend
  import mtf_pkg::*;
#(
  parameter int FRAC   = 8,
  parameter int WT_CUR = 154,
  parameter bit ROUND  = 1'b1
) (
  input  pix_t cur_i,
  input  pix_t prev_i,
  output pix_t blend_o
);
  localparam int SW      = PIX_W + FRAC + 1;
  localparam int WT_PREV = (1 << FRAC) - WT_CUR;
  localparam logic [SW-1:0] MAXV = SW'((1 << PIX_W) - 1);

  logic [SW-1:0] prod_c, prod_p, sum, shifted;

  assign prod_c = SW'(cur_i)  * SW'(WT_CUR);
  assign prod_p = SW'(prev_i) * SW'(WT_PREV);

  generate
    if (ROUND) begin : g_round
      assign sum = prod_c + prod_p + SW'(1 << (FRAC - 1));
    end else begin : g_trunc
      assign sum = prod_c + prod_p;
    end
  endgenerate

  assign shifted = sum >> FRAC;
  assign blend_o = (shifted > MAXV) ? MAXV[PIX_W-1:0] : shifted[PIX_W-1:0];
endmodule

// File: rtl/motion_temporal_filter.sv
module motion_temporal_filter
  import mtf_pkg::*;
#(
  parameter int   FRAC    = 8,
  parameter int   WT_CUR  = 154,
  parameter bit   ROUND   = 1'b1,
  parameter pix_t THR_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             field_start_i,
  input  logic [PIX_W-1:0] cur_px_i,
  input  logic [PIX_W-1:0] prev_px_i,
  input  logic [PIX_W-1:0] thresh_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] px_o
);
  pix_t   thr_act, thr_q, blend;
  logic   motion;
  stage_t s1;

  mtf_thresh_reg #(.THR_RST(THR_RST)) u_thr (
    .clk_i, .rst_ni, .valid_i, .field_start_i, .thresh_i,
    .thr_act_o(thr_act), .thr_q_o(thr_q)
  );

  mtf_motion_det u_det (
    .cur_i(cur_px_i), .prev_i(prev_px_i), .thr_i(thr_act), .motion_o(motion)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= '0;
    end else begin
      s1.vld <= valid_i;
      if (valid_i) begin
        s1.mot  <= motion;
        s1.cur  <= cur_px_i;
        s1.prev <= prev_px_i;
      end
    end
  end

  mtf_blend #(.FRAC(FRAC), .WT_CUR(WT_CUR), .ROUND(ROUND)) u_blend (
    .cur_i(s1.cur), .prev_i(s1.prev), .blend_o(blend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      px_o    <= '0;
    end else begin
      valid_o <= s1.vld;
      if (s1.vld) px_o <= s1.mot ? s1.cur : blend;
    end
  end
endmodule

// File: rtl/mtf_checker.sv
module mtf_checker
  import mtf_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic field_start_i,
  input pix_t cur_px_i,
  input pix_t prev_px_i,
  input pix_t thr_act,
  input pix_t thr_q,
  input logic valid_o,
  input pix_t px_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       age <= '0;
    else if (age != 3) age <= age + 2'd1;
  end

  function automatic pix_t adiff(pix_t a, pix_t b);
    return (a >= b) ? a - b : b - a;
  endfunction

  function automatic pix_t pmin(pix_t a, pix_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic pix_t pmax(pix_t a, pix_t b);
    return (a < b) ? b : a;
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk_i) (age == 0) |-> (!valid_o && px_o == '0)); // R1

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2) |-> (valid_o == $past(valid_i, 2))); // R2

  AST_STATIC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 2) && valid_o &&
     adiff($past(cur_px_i, 2), $past(prev_px_i, 2)) < $past(thr_act, 2))
    |-> (px_o >= pmin($past(cur_px_i, 2), $past(prev_px_i, 2)) &&
         px_o <= pmax($past(cur_px_i, 2), $past(prev_px_i, 2)))); // R3

  AST_MOTION_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 2) && valid_o &&
     !(adiff($past(cur_px_i, 2), $past(prev_px_i, 2)) < $past(thr_act, 2)))
    |-> (px_o == $past(cur_px_i, 2))); // R4

  AST_THR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 1) && !(valid_i && field_start_i)) |=> $stable(thr_q)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 1) && !valid_o) |-> $stable(px_o)); // R7
endmodule

bind motion_temporal_filter mtf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .field_start_i(field_start_i),
  .cur_px_i(cur_px_i), .prev_px_i(prev_px_i), .thr_act(thr_act), .thr_q(thr_q),
  .valid_o(valid_o), .px_o(px_o)
);

// File: tb/motion_temporal_filter_test.sv
`timescale 1ns/1ps
module motion_temporal_filter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       field_start_i = 1'b0;
  logic [7:0] cur_px_i = '0;
  logic [7:0] prev_px_i = '0;
  logic [7:0] thresh_i = '0;
  logic       valid_o;
  logic [7:0] px_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  motion_temporal_filter uut (
    .clk_i, .rst_ni, .valid_i, .field_start_i, .cur_px_i, .prev_px_i,
    .thresh_i, .valid_o, .px_o
  );

  function automatic int blend(int c, int p);
    return (154 * c + 102 * p + 128) >> 8;
  endfunction

  function automatic int expect_px(int c, int p, int thr);
    int d;
    d = (c > p) ? c - p : p - c;
    return (d < thr) ? blend(c, p) : c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one pixel, checks latency and value
  task automatic one_px(string req, int c, int p, bit fs, int thr_in, int exp);
    @(negedge clk_i);
    valid_i = 1; field_start_i = fs; cur_px_i = 8'(c); prev_px_i = 8'(p); thresh_i = 8'(thr_in);
    @(negedge clk_i);
    valid_i = 0; field_start_i = 0;
    check({req, " R2 no early valid"}, int'(valid_o), 0);
    @(negedge clk_i);
    check({req, " R2 valid"}, int'(valid_o), 1);
    check(req, int'(px_o), exp);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", int'(valid_o), 0);
    check("R1 px_o in reset", int'(px_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 px_o after reset", int'(px_o), 0);
  endtask

  task automatic t_reset_thr();
    one_px("R1 zero threshold passes", 100, 100, 0, 0, 100);
  endtask

  task automatic t_field_thr();
    one_px("R5 no load without field start", 100, 90, 0, 40, 100);
    one_px("R5 load at field start", 100, 90, 1, 40, blend(100, 90));
    one_px("R3 blend under held threshold", 60, 80, 0, 0, blend(60, 80));
    one_px("R5 change ignored mid field", 60, 80, 0, 5, blend(60, 80));
  endtask

  task automatic t_edge();
    one_px("R5 reload", 10, 10, 1, 20, 10);
    one_px("R4 diff equals threshold", 130, 110, 0, 0, 130);
    one_px("R3 diff one below threshold", 129, 110, 0, 0, blend(129, 110));
    one_px("R4 large motion", 0, 200, 0, 0, 0);
  endtask

  task automatic t_clamp();
    one_px("R6 high static", 255, 255, 1, 255, 255);
    one_px("R6 low static", 0, 0, 0, 0, 0);
    one_px("R6 near top", 255, 1, 0, 0, blend(255, 1));
  endtask

  task automatic t_stream();
    int n = 40;
    int ec[40];
    bit ev[40];
    int held;
    for (int j = 0; j < n + 2; j++) begin
      @(negedge clk_i);
      if (j >= 2) begin
        check("R2 stream valid", int'(valid_o), int'(ev[j-2]));
        if (ev[j-2]) check("R3 R4 stream value", int'(px_o), ec[j-2]);
        else         check("R7 hold when idle", int'(px_o), held);
        held = int'(px_o);
      end else begin
        held = int'(px_o);
      end
      if (j < n) begin
        int c, p;
        c = (j * 37 + 11) & 255;
        p = (j % 3 == 0) ? ((c + 45) & 255) : ((c + (j % 29)) & 255);
        ev[j] = (j % 5) != 3;
        ec[j] = expect_px(c, p, 30);
        valid_i = ev[j]; field_start_i = (j == 0);
        cur_px_i = 8'(c); prev_px_i = 8'(p); thresh_i = (j == 0) ? 8'd30 : 8'(j);
      end else begin
        valid_i = 0; field_start_i = 0;
      end
    end
  endtask

  initial begin
    t_reset();
    t_reset_thr();
    t_field_thr();
    t_edge();
    t_clamp();
    t_stream();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule